// File: doc/BRIEF.md
# Dual-Window Packed Byte SAD Engine

This block compares a reference vector with a candidate vector, both made of unsigned bytes, and returns 16-bit sum-of-absolute-difference words. First, an 8-bit selector reorders the four 32-bit dwords of the candidate inside every 128-bit lane. Then, in every 64-bit superblock, four sliding byte windows of the reordered candidate are scored against the two fixed reference dwords of that superblock.

A per-word write mask chooses which of the computed words reach the output. Each word whose mask bit is cleared either keeps the matching word of a prior destination vector or is forced to zero. Masking can be switched off entirely. The active vector width is a parameter (128, 256 or 512 bits). The output is always as wide as the largest width, and everything above the active width reads as zero. One registered stage sits between an accepted operand set and the result.

Top module: `block_sad_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` becomes 0 and `result` becomes all zeros.
- R2: Within each 128-bit lane, shuffled dword p (p = 0..3, counted from bit 0) is the candidate dword whose index is `shuf_ctl[2p+1:2p]`. Code 0 picks the lowest dword and code 3 the highest.
- R3: In each 64-bit superblock, with bytes numbered from 0 at the low end, word k (k = 0..3, at bits 16k+15:16k) sums four pairs. The pairs take reference bytes b..b+3, where b = 0 for k < 2 and b = 4 otherwise, and pair them in order with shuffled bytes k..k+3.
- R4: Bytes are compared as unsigned values using the absolute difference. A word can reach at most 1020, which is zero-extended into its 16 bits.
- R5: When `mask_en` is 0, every active word carries its computed sum, whatever `wmask` holds.
- R6: When `mask_en` is 1, `zero_fill` is 0 and `wmask[w]` is 0, word w equals word w of `prior_dst`.
- R7: When `mask_en` is 1, `zero_fill` is 1 and `wmask[w]` is 0, word w is zero. When `wmask[w]` is 1, word w is the computed sum under either policy.
- R8: Bits of `result` at and above VEC_W are always zero.
- R9: `out_valid` is `in_valid` delayed by one clock. `result` takes a new value only on an edge where `in_valid` is 1, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented this cycle |
| ref_vec | input | VEC_W | Reference bytes (stationary side) |
| cand_vec | input | VEC_W | Candidate bytes (shuffled, sliding side) |
| shuf_ctl | input | 8 | Dword selector codes, two bits per destination dword |
| mask_en | input | 1 | 1 applies `wmask`, 0 writes all words |
| zero_fill | input | 1 | Masked-off word policy: 1 zero, 0 keep prior |
| wmask | input | VEC_W/16 | Per-word write enable |
| prior_dst | input | VEC_W | Previous destination contents for merging |
| out_valid | output | 1 | `result` was produced from the last accepted operands |
| result | output | MAX_W | Result words, zero above VEC_W |

## Verification
Within a single result, computed words sit next to words that are masked off. In the same superblock, a masked word and a computed word both read the same shuffled dwords. The bench provokes this with alternating and sparse mask patterns under both fill policies, and drives `prior_dst` with a distinctive all-ones pattern so that a kept word can be told apart from a computed one. Every word is judged against an independent byte-level model. The bits above the active width are judged at the same time, and they must stay zero even when the prior vector is all ones.

// File: rtl/bsad_pkg.sv
package bsad_pkg;

    localparam int LANE_W = 128;
    localparam int SB_W   = 64;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int DW_W   = 32;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        POL_WRITE = 2'd0,
        POL_KEEP  = 2'd1,
        POL_CLEAR = 2'd2
    } fill_pol_e;

    function automatic byte_t abs_diff(input byte_t a, input byte_t b);
        return (a > b) ? byte_t'(a - b) : byte_t'(b - a);
    endfunction

    function automatic word_t quad_sad(input logic [DW_W-1:0] r, input logic [DW_W-1:0] c);
        word_t acc;
        acc = '0;
        for (int j = 0; j < 4; j++) begin
            acc = acc + word_t'(abs_diff(r[BYTE_W*j +: BYTE_W], c[BYTE_W*j +: BYTE_W]));
        end
        return acc;
    endfunction

    function automatic fill_pol_e pick_policy(input logic en, input logic zf, input logic bit_on);
        if (!en || bit_on) return POL_WRITE;
        return zf ? POL_CLEAR : POL_KEEP;
    endfunction

endpackage

// File: rtl/lane_shuffler.sv
module lane_shuffler
    import bsad_pkg::*;
(
    input  logic [LANE_W-1:0] lane_in,
    input  logic [7:0]        sel,
    output logic [LANE_W-1:0] lane_out
);
    localparam int NDW = LANE_W / DW_W;

    for (genvar p = 0; p < NDW; p++) begin : g_dw
        logic [1:0] code;
        assign code = sel[2*p +: 2];
        always_comb begin
            lane_out[DW_W*p +: DW_W] = lane_in[DW_W*code +: DW_W];
        end
    end
endmodule

// File: rtl/superblock_sad.sv
module superblock_sad
    import bsad_pkg::*;
(
    input  logic [SB_W-1:0] ref_sb,
    input  logic [SB_W-1:0] shuf_sb,
    output logic [SB_W-1:0] sad_sb
);
    for (genvar k = 0; k < 4; k++) begin : g_win
        localparam int REF_LO = (k < 2) ? 0 : DW_W;
        localparam int WIN_LO = BYTE_W * k;
        assign sad_sb[WORD_W*k +: WORD_W] =
            quad_sad(ref_sb[REF_LO +: DW_W], shuf_sb[WIN_LO +: DW_W]);
    end
endmodule

// File: rtl/word_masker.sv
module word_masker
    import bsad_pkg::*;
#(
    parameter int N_WORDS = 16
) (
    input  logic [N_WORDS*WORD_W-1:0] calc,
    input  logic [N_WORDS*WORD_W-1:0] prior,
    input  logic [N_WORDS-1:0]        wmask,
    input  logic                      mask_en,
    input  logic                      zero_fill,
    output logic [N_WORDS*WORD_W-1:0] merged
);
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        fill_pol_e pol;
        assign pol = pick_policy(mask_en, zero_fill, wmask[w]);
        always_comb begin
            unique case (pol)
                POL_WRITE: merged[WORD_W*w +: WORD_W] = calc[WORD_W*w +: WORD_W];
                POL_KEEP:  merged[WORD_W*w +: WORD_W] = prior[WORD_W*w +: WORD_W];
                default:   merged[WORD_W*w +: WORD_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/block_sad_engine.sv
module block_sad_engine
    import bsad_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int MAX_W = 512,
    localparam int N_WORDS = VEC_W / WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   ref_vec,
    input  logic [VEC_W-1:0]   cand_vec,
    input  logic [7:0]         shuf_ctl,
    input  logic               mask_en,
    input  logic               zero_fill,
    input  logic [N_WORDS-1:0] wmask,
    input  logic [VEC_W-1:0]   prior_dst,
    output logic               out_valid,
    output logic [MAX_W-1:0]   result
);
    localparam int N_LANES = VEC_W / LANE_W;
    localparam int N_SB    = VEC_W / SB_W;

    logic [VEC_W-1:0] shuf_vec;
    logic [VEC_W-1:0] sad_vec;
    logic [VEC_W-1:0] masked_vec;
    logic [VEC_W-1:0] res_q;
    logic             vld_q;

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        lane_shuffler u_shuf (
            .lane_in  (cand_vec[LANE_W*l +: LANE_W]),
            .sel      (shuf_ctl),
            .lane_out (shuf_vec[LANE_W*l +: LANE_W])
        );
    end

    for (genvar s = 0; s < N_SB; s++) begin : g_sb
        superblock_sad u_sad (
            .ref_sb  (ref_vec[SB_W*s +: SB_W]),
            .shuf_sb (shuf_vec[SB_W*s +: SB_W]),
            .sad_sb  (sad_vec[SB_W*s +: SB_W])
        );
    end

    word_masker #(.N_WORDS(N_WORDS)) u_mask (
        .calc      (sad_vec),
        .prior     (prior_dst),
        .wmask     (wmask),
        .mask_en   (mask_en),
        .zero_fill (zero_fill),
        .merged    (masked_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= masked_vec;
        end
    end

    assign out_valid = vld_q;

    if (VEC_W < MAX_W) begin : g_pad
        assign result = {{(MAX_W-VEC_W){1'b0}}, res_q};
    end else begin : g_nopad
        assign result = res_q;
    end
endmodule

// File: rtl/bsad_checker.sv
module bsad_checker
    import bsad_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int MAX_W = 512,
    localparam int N_WORDS = VEC_W / WORD_W
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               mask_en,
    input logic               zero_fill,
    input logic [N_WORDS-1:0] wmask,
    input logic [VEC_W-1:0]   prior_dst,
    input logic               out_valid,
    input logic [MAX_W-1:0]   result
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result)); // R9

    if (VEC_W < MAX_W) begin : g_upper
        AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst) result[MAX_W-1:VEC_W] == '0); // R8
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_w
        AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mask_en && zero_fill && !wmask[w]) |=> result[WORD_W*w +: WORD_W] == '0); // R7
        AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mask_en && !zero_fill && !wmask[w]) |=>
            result[WORD_W*w +: WORD_W] == $past(prior_dst[WORD_W*w +: WORD_W])); // R6
        AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (!mask_en || wmask[w])) |=> result[WORD_W*w +: WORD_W] <= 16'd1020); // R4
    end
endmodule

bind block_sad_engine bsad_checker #(.VEC_W(VEC_W), .MAX_W(MAX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mask_en   (mask_en),
    .zero_fill (zero_fill),
    .wmask     (wmask),
    .prior_dst (prior_dst),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_block_sad_engine.sv
`timescale 1ns/1ps
module sim_block_sad_engine;
    localparam int VW = 256;
    localparam int MW = 512;
    localparam int NW = VW / 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VW-1:0] ref_vec = '0;
    logic [VW-1:0] cand_vec = '0;
    logic [7:0]    shuf_ctl = '0;
    logic          mask_en = 1'b0;
    logic          zero_fill = 1'b0;
    logic [NW-1:0] wmask = '0;
    logic [VW-1:0] prior_dst = '0;
    logic          out_valid;
    logic [MW-1:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    block_sad_engine #(.VEC_W(VW), .MAX_W(MW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ref_vec(ref_vec), .cand_vec(cand_vec),
        .shuf_ctl(shuf_ctl), .mask_en(mask_en), .zero_fill(zero_fill), .wmask(wmask),
        .prior_dst(prior_dst), .out_valid(out_valid), .result(result)
    );

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW/32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [MW-1:0] model(input logic [VW-1:0] r, input logic [VW-1:0] c,
                                            input logic [7:0] sel, input logic me, input logic zf,
                                            input logic [NW-1:0] wm, input logic [VW-1:0] pd);
        logic [VW-1:0] sh;
        logic [MW-1:0] o;
        o = '0;
        for (int l = 0; l < VW/128; l++)
            for (int p = 0; p < 4; p++)
                sh[128*l + 32*p +: 32] = c[128*l + 32*int'(sel[2*p +: 2]) +: 32];
        for (int w = 0; w < NW; w++) begin
            int sb, k, rb, acc, a, b;
            sb = w / 4; k = w % 4; rb = (k < 2) ? 0 : 4; acc = 0;
            for (int j = 0; j < 4; j++) begin
                a = int'(r[64*sb + 8*(rb+j) +: 8]);
                b = int'(sh[64*sb + 8*(k+j) +: 8]);
                acc += (a > b) ? a - b : b - a;
            end
            if (!me || wm[w]) o[16*w +: 16] = 16'(acc);
            else if (zf)      o[16*w +: 16] = 16'd0;
            else              o[16*w +: 16] = pd[16*w +: 16];
        end
        return o;
    endfunction

    task automatic check_result(input string tag, input logic [MW-1:0] exp);
        for (int w = 0; w < NW; w++) begin
            n_chk++;
            if (result[16*w +: 16] !== exp[16*w +: 16]) begin
                n_bad++;
                $display("FAIL %s word %0d: actual %h expected %h", tag, w, result[16*w +: 16], exp[16*w +: 16]);
            end
        end
        n_chk++;
        if (result[MW-1:VW] !== '0) begin
            n_bad++;
            $display("FAIL R8 upper bits: actual %h expected 0", result[MW-1:VW]);
        end
        n_chk++;
        if (out_valid !== 1'b1) begin
            n_bad++;
            $display("FAIL R9 out_valid: actual %b expected 1", out_valid);
        end
    endtask

    task automatic run_one(input string tag, input logic [VW-1:0] r, input logic [VW-1:0] c,
                           input logic [7:0] sel, input logic me, input logic zf,
                           input logic [NW-1:0] wm, input logic [VW-1:0] pd);
        @(negedge clk);
        ref_vec = r; cand_vec = c; shuf_ctl = sel; mask_en = me; zero_fill = zf;
        wmask = wm; prior_dst = pd; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_result(tag, model(r, c, sel, me, zf, wm, pd));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || result !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: actual v=%b res=%h expected v=0 res=0", out_valid, result);
        end
        rst = 1'b0;
    endtask

    task automatic t_shuffle_sweep();
        for (int s = 0; s < 256; s++)
            run_one("R2/R3 selector sweep", rnd_vec(), rnd_vec(), 8'(s), 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++)
            run_one("R3 random", rnd_vec(), rnd_vec(), 8'($urandom), 1'b0, 1'b0, NW'($urandom), rnd_vec());
    endtask

    task automatic t_equal();
        logic [VW-1:0] v;
        v = rnd_vec();
        run_one("R3 equal operands", v, v, 8'hE4, 1'b0, 1'b0, '0, '0);
        run_one("R3 equal bytes", {(VW/8){8'h5A}}, {(VW/8){8'h5A}}, 8'h1B, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_maxdiff();
        run_one("R4 max diff lo-hi", '0, '1, 8'h00, 1'b0, 1'b0, '0, '0);
        run_one("R4 max diff hi-lo", '1, '0, 8'hFF, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_nomask();
        run_one("R5 mask disabled", rnd_vec(), rnd_vec(), 8'h93, 1'b0, 1'b1, '0, '1);
    endtask

    task automatic t_merge();
        run_one("R6 merge alternating", rnd_vec(), rnd_vec(), 8'h4E, 1'b1, 1'b0, NW'(16'hAAAA), '1);
        run_one("R6 merge sparse", rnd_vec(), rnd_vec(), 8'hB1, 1'b1, 1'b0, NW'(16'h8421), rnd_vec());
    endtask

    task automatic t_zero();
        run_one("R7 zero alternating", rnd_vec(), rnd_vec(), 8'h39, 1'b1, 1'b1, NW'(16'h5555), '1);
        run_one("R7 zero all off", rnd_vec(), rnd_vec(), 8'hC6, 1'b1, 1'b1, '0, '1);
        run_one("R7 all on", rnd_vec(), rnd_vec(), 8'h27, 1'b1, 1'b1, '1, '1);
    endtask

    task automatic t_hold();
        logic [MW-1:0] snap;
        run_one("R9 before hold", rnd_vec(), rnd_vec(), 8'h72, 1'b0, 1'b0, '0, '0);
        snap = result;
        ref_vec = rnd_vec(); cand_vec = rnd_vec(); prior_dst = '1;
        repeat (3) @(negedge clk);
        n_chk++;
        if (result !== snap || out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 hold: actual v=%b res=%h expected v=0 res=%h", out_valid, result, snap);
        end
    endtask

    initial begin
        t_reset();
        t_shuffle_sweep();
        t_random();
        t_equal();
        t_maxdiff();
        t_nomask();
        t_merge();
        t_zero();
        t_hold();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule